// File: doc/BRIEF.md
# GPIO Interrupt Detector Bank

This block watches a bank of general-purpose input lines and raises interrupts when they change. Each line has its own trigger setting. It can fire on a rising edge, a falling edge, either edge, a high level or a low level. Each input is first brought into the local clock domain. A detection sets a sticky status bit for that line. Software clears a status bit by writing a one to it.

A single interrupt output reports whether any status bit is pending while its line is enabled. Software reaches the bank through a small word-addressed register port. Writes take effect on the clock edge. Reads are combinational on the address. Beside the interrupt words, the port also shows the synchronised input levels and holds a word that drives an output bus.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset the enable, polarity, level-select and status words read 0, the both-edges word reads all ones, the drive word reads 0, and `irq_o` is low.
- R2: Byte addresses: 0x00 enable, 0x04 polarity (1 = rising/high, 0 = falling/low), 0x08 level-select (1 = level, 0 = edge), 0x0C both-edges, 0x10 status, 0x14 input level (read only), 0x18 drive. A written word reads back unchanged. Any other address reads 0.
- R3: Each input passes two synchroniser flops. A pin change applied before clock edge k first shows in the level word after edge k+1 and in the status word after edge k+2, not earlier.
- R4: With level-select 0, both-edges 0 and polarity 1, only a rising edge sets the pin's status bit.
- R5: With level-select 0, both-edges 0 and polarity 0, only a falling edge sets the pin's status bit.
- R6: With level-select 0 and both-edges 1, rising and falling edges both set the status bit, whatever the polarity bit holds.
- R7: With level-select 1, the status bit is set while the synchronised input equals the polarity bit. It cannot be cleared while that level persists, and it can be cleared once the level is gone.
- R8: Writing to the status word clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R9: When a detection and a clearing write hit the same status bit on the same edge, the bit stays set.
- R10: A status bit is set by detection even while its enable bit is 0. A pending but disabled bit never raises `irq_o`.
- R11: `irq_o` is registered. It rises one edge after a status bit becomes both set and enabled, and it falls one edge after no such bit remains.
- R12: The input level word shows the synchronised pins, and the drive word appears on `drive_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 32 | Asynchronous input lines |
| reg_wr_i | input | 1 | Write strobe for the register port |
| reg_addr_i | input | 5 | Byte address of the register word |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, combinational on the address |
| irq_o | output | 1 | Aggregate interrupt: any enabled pending status bit |
| drive_o | output | 32 | Contents of the drive word |

## Verification
The hardest case to reach is a clearing write to the status word that lands on exactly the same edge on which a new edge detection sets that bit. The bench reaches it by counting the synchroniser stages. It changes a pin at a falling clock edge. It then waits two rising edges and asserts the write strobe, so that the write and the detection commit on the third edge. A second hard case is a level-triggered pin that cannot be cleared while its level is held. The bench tries a clear while the level is still asserted, then tries again after the level drops.

// File: rtl/gpio_irq_bank_pkg.sv
package gpio_irq_bank_pkg;

  localparam logic [7:0] OFS_ENABLE = 8'h00;
  localparam logic [7:0] OFS_POLAR  = 8'h04;
  localparam logic [7:0] OFS_LEVSEL = 8'h08;
  localparam logic [7:0] OFS_BOTH   = 8'h0C;
  localparam logic [7:0] OFS_STATUS = 8'h10;
  localparam logic [7:0] OFS_LEVEL  = 8'h14;
  localparam logic [7:0] OFS_DRIVE  = 8'h18;

  // Trigger decision for one pin from its three configuration bits.
  function automatic logic trig_hit(input logic lev_mode, input logic polar,
                                    input logic both, input logic now_v,
                                    input logic old_v);
    logic rise, fall;
    rise = now_v & ~old_v;
    fall = ~now_v & old_v;
    if (lev_mode)  return (now_v == polar);
    else if (both) return rise | fall;
    else           return polar ? rise : fall;
  endfunction

  // Next status bit: a detection outranks a write-one clear.
  function automatic logic stat_next(input logic cur, input logic clr,
                                     input logic hit);
    return hit | (cur & ~clr);
  endfunction

endpackage

// File: rtl/irqbank_sync.sv
module irqbank_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);

  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
    end else begin
      stage_q[0] <= async_i;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/irqbank_detect.sv
module irqbank_detect
  import gpio_irq_bank_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] level_i,
  input  logic [W-1:0] polar_i,
  input  logic [W-1:0] levsel_i,
  input  logic [W-1:0] both_i,
  output logic [W-1:0] hit_o
);

  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= level_i;
  end

  for (genvar b = 0; b < W; b++) begin : g_pin
    assign hit_o[b] = trig_hit(levsel_i[b], polar_i[b], both_i[b],
                               level_i[b], prev_q[b]);
  end

  // An edge-mode pin never reports a hit while its input holds still.
  AST_EDGE_NEEDS_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    ((hit_o & ~levsel_i & ~(level_i ^ prev_q)) == '0)); // R6

endmodule

// File: rtl/irqbank_regs.sv
module irqbank_regs
  import gpio_irq_bank_pkg::*;
#(
  parameter int W  = 32,
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  input  logic [W-1:0]  wdata_i,
  output logic [W-1:0]  rdata_o,
  input  logic [W-1:0]  hit_i,
  input  logic [W-1:0]  level_i,
  output logic [W-1:0]  polar_o,
  output logic [W-1:0]  levsel_o,
  output logic [W-1:0]  both_o,
  output logic [W-1:0]  drive_o,
  output logic          irq_o
);

  logic [W-1:0] enable_q, polar_q, levsel_q, both_q, drive_q, status_q;
  logic [W-1:0] clr_mask, status_d;
  logic [7:0]   ofs;
  logic         irq_q;

  assign ofs      = 8'(addr_i);
  assign clr_mask = (wr_i && ofs == OFS_STATUS) ? wdata_i : '0;

  for (genvar b = 0; b < W; b++) begin : g_stat
    assign status_d[b] = stat_next(status_q[b], clr_mask[b], hit_i[b]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable_q <= '0;
      polar_q  <= '0;
      levsel_q <= '0;
      both_q   <= '1;
      drive_q  <= '0;
      status_q <= '0;
      irq_q    <= 1'b0;
    end else begin
      if (wr_i) begin
        case (ofs)
          OFS_ENABLE: enable_q <= wdata_i;
          OFS_POLAR:  polar_q  <= wdata_i;
          OFS_LEVSEL: levsel_q <= wdata_i;
          OFS_BOTH:   both_q   <= wdata_i;
          OFS_DRIVE:  drive_q  <= wdata_i;
          default: ;
        endcase
      end
      status_q <= status_d;
      irq_q    <= |(status_q & enable_q);
    end
  end

  always_comb begin
    case (ofs)
      OFS_ENABLE: rdata_o = enable_q;
      OFS_POLAR:  rdata_o = polar_q;
      OFS_LEVSEL: rdata_o = levsel_q;
      OFS_BOTH:   rdata_o = both_q;
      OFS_STATUS: rdata_o = status_q;
      OFS_LEVEL:  rdata_o = level_i;
      OFS_DRIVE:  rdata_o = drive_q;
      default:    rdata_o = '0;
    endcase
  end

  assign polar_o  = polar_q;
  assign levsel_o = levsel_q;
  assign both_o   = both_q;
  assign drive_o  = drive_q;
  assign irq_o    = irq_q;

  AST_DETECT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_q & $past(hit_i)) == $past(hit_i))); // R9
  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_q & $past(clr_mask) & ~$past(hit_i)) == '0)); // R8
  AST_STICKY_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_q & ~$past(status_q) & ~$past(hit_i)) == '0)); // R10
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ((status_q & enable_q) == '0) |=> !irq_q); // R11
  AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    ((status_q & enable_q) != '0) |=> irq_q); // R11

endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank #(
  parameter int W           = 32,
  parameter int AW          = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [W-1:0]  pin_i,
  input  logic          reg_wr_i,
  input  logic [AW-1:0] reg_addr_i,
  input  logic [W-1:0]  reg_wdata_i,
  output logic [W-1:0]  reg_rdata_o,
  output logic          irq_o,
  output logic [W-1:0]  drive_o
);

  logic [W-1:0] level_w, hit_w, polar_w, levsel_w, both_w;

  irqbank_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (pin_i),
    .sync_o  (level_w)
  );

  irqbank_detect #(.W(W)) u_detect (
    .clk      (clk),
    .rst_n    (rst_n),
    .level_i  (level_w),
    .polar_i  (polar_w),
    .levsel_i (levsel_w),
    .both_i   (both_w),
    .hit_o    (hit_w)
  );

  irqbank_regs #(.W(W), .AW(AW)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_i     (reg_wr_i),
    .addr_i   (reg_addr_i),
    .wdata_i  (reg_wdata_i),
    .rdata_o  (reg_rdata_o),
    .hit_i    (hit_w),
    .level_i  (level_w),
    .polar_o  (polar_w),
    .levsel_o (levsel_w),
    .both_o   (both_w),
    .drive_o  (drive_o),
    .irq_o    (irq_o)
  );

endmodule

// File: tb/gpio_irq_bank_bench.sv
`timescale 1ns/1ps
module gpio_irq_bank_bench;

  localparam logic [4:0] A_EN = 5'h00, A_POL = 5'h04, A_LEV = 5'h08,
                         A_BOTH = 5'h0C, A_STAT = 5'h10, A_LVL = 5'h14,
                         A_DRV = 5'h18;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] pin_in = '0;
  logic        reg_wr = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;
  logic [31:0] drive;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  done  = 1'b0;
  logic [31:0] sh_pol = '0, sh_lev = '0, sh_both = '1;

  always #2 clk = ~clk;

  gpio_irq_bank u_gpio_irq_bank (
    .clk (clk), .rst_n (rst_n), .pin_i (pin_in), .reg_wr_i (reg_wr),
    .reg_addr_i (reg_addr), .reg_wdata_i (reg_wdata),
    .reg_rdata_o (reg_rdata), .irq_o (irq), .drive_o (drive)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] v);
    reg_addr = a;
    #0.5;
    v = reg_rdata;
  endtask

  task automatic stat_bit(input string tag, input int b, input logic exp);
    logic [31:0] v;
    rd(A_STAT, v);
    chk(tag, 32'(v[b]), 32'(exp));
  endtask

  task automatic setpin(input int b, input logic v);
    @(negedge clk);
    pin_in[b] = v;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(A_EN, v);   chk("R1 enable", v, 32'h0);
    rd(A_POL, v);  chk("R1 polarity", v, 32'h0);
    rd(A_LEV, v);  chk("R1 level-select", v, 32'h0);
    rd(A_BOTH, v); chk("R1 both-edges", v, 32'hFFFF_FFFF);
    rd(A_STAT, v); chk("R1 status", v, 32'h0);
    rd(A_DRV, v);  chk("R1 drive", v, 32'h0);
    chk("R1 irq", 32'(irq), 32'h0);
    rd(5'h1C, v);  chk("R2 unmapped reads zero", v, 32'h0);
  endtask

  task automatic t_regmap;
    logic [31:0] v;
    wr(A_POL, 32'h1234_5678); rd(A_POL, v); chk("R2 polarity readback", v, 32'h1234_5678);
    wr(A_POL, 32'h0);
    wr(A_EN, 32'hA5A5_0000);  rd(A_EN, v);  chk("R2 enable readback", v, 32'hA5A5_0000);
    wr(A_EN, 32'h0);
  endtask

  task automatic t_sync_timing;
    // bit 0: reset default is dual-edge; enable is 0
    setpin(0, 1'b1);
    step(1); stat_bit("R3 status after 1 edge", 0, 1'b0);
    step(1); stat_bit("R3 status after 2 edges", 0, 1'b0);
    step(1); stat_bit("R3 status after 3 edges", 0, 1'b1);
    step(1); chk("R10 disabled pending keeps irq low", 32'(irq), 32'h0);
    wr(A_STAT, 32'h1); stat_bit("R8 clear bit0", 0, 1'b0);
  endtask

  task automatic t_rise;
    sh_both[1] = 1'b0; sh_pol[1] = 1'b1;
    wr(A_POL, sh_pol); wr(A_BOTH, sh_both);
    setpin(1, 1'b1); step(3); stat_bit("R4 rising sets", 1, 1'b1);
    wr(A_STAT, 32'h2);
    setpin(1, 1'b0); step(3); stat_bit("R4 falling ignored", 1, 1'b0);
  endtask

  task automatic t_fall;
    sh_both[2] = 1'b0;
    wr(A_BOTH, sh_both);
    setpin(2, 1'b1); step(3); stat_bit("R5 rising ignored", 2, 1'b0);
    setpin(2, 1'b0); step(3); stat_bit("R5 falling sets", 2, 1'b1);
    wr(A_STAT, 32'h4);
  endtask

  task automatic t_dual;
    sh_pol[3] = 1'b1;
    wr(A_POL, sh_pol);
    setpin(3, 1'b1); step(3); stat_bit("R6 rising sets in dual", 3, 1'b1);
    wr(A_STAT, 32'h8); stat_bit("R6 cleared", 3, 1'b0);
    setpin(3, 1'b0); step(3); stat_bit("R6 falling sets in dual", 3, 1'b1);
    wr(A_STAT, 32'h8);
  endtask

  task automatic t_level;
    sh_pol[4] = 1'b1; wr(A_POL, sh_pol);
    sh_lev[4] = 1'b1; wr(A_LEV, sh_lev);
    step(2); stat_bit("R7 high-level idle low", 4, 1'b0);
    setpin(4, 1'b1); step(3); stat_bit("R7 high level sets", 4, 1'b1);
    wr(A_STAT, 32'h10); stat_bit("R7 held level resists clear", 4, 1'b1);
    setpin(4, 1'b0); step(3);
    wr(A_STAT, 32'h10); stat_bit("R7 clear after level gone", 4, 1'b0);
    sh_lev[5] = 1'b1; wr(A_LEV, sh_lev);
    step(1); stat_bit("R7 low level sets", 5, 1'b1);
    setpin(5, 1'b1); step(3);
    wr(A_STAT, 32'h20); stat_bit("R7 low level cleared after rise", 5, 1'b0);
  endtask

  task automatic t_w1c;
    logic [31:0] v;
    @(negedge clk); pin_in[7] = 1'b1; pin_in[8] = 1'b1;
    step(3); rd(A_STAT, v); chk("R8 both set", v & 32'h180, 32'h180);
    wr(A_STAT, 32'h0);   rd(A_STAT, v); chk("R8 zero write keeps", v & 32'h180, 32'h180);
    wr(A_STAT, 32'h80);  rd(A_STAT, v); chk("R8 one clears only its bit", v & 32'h180, 32'h100);
    wr(A_STAT, 32'h100); rd(A_STAT, v); chk("R8 second clear", v & 32'h180, 32'h0);
  endtask

  task automatic t_wins;
    setpin(9, 1'b1); step(3); stat_bit("R9 initial set", 9, 1'b1);
    @(negedge clk); pin_in[9] = 1'b0;
    @(negedge clk);
    @(negedge clk); reg_wr = 1'b1; reg_addr = A_STAT; reg_wdata = 32'h200;
    @(negedge clk); reg_wr = 1'b0;
    stat_bit("R9 detection beats clear", 9, 1'b1);
    wr(A_STAT, 32'h200); stat_bit("R9 later clear works", 9, 1'b0);
  endtask

  task automatic t_irq;
    wr(A_EN, 32'h400);
    setpin(10, 1'b1); step(3);
    stat_bit("R11 status set", 10, 1'b1);
    chk("R11 irq not yet", 32'(irq), 32'h0);
    step(1); chk("R11 irq one edge later", 32'(irq), 32'h1);
    wr(A_STAT, 32'h400);
    chk("R11 irq holds one edge after clear", 32'(irq), 32'h1);
    step(1); chk("R11 irq falls", 32'(irq), 32'h0);
    setpin(11, 1'b1); step(4);
    stat_bit("R10 disabled pin still latches", 11, 1'b1);
    chk("R10 disabled pin no irq", 32'(irq), 32'h0);
    wr(A_STAT, 32'h800); wr(A_EN, 32'h0);
  endtask

  task automatic t_level_drive;
    logic [31:0] v;
    @(negedge clk); pin_in[23:20] = 4'b1010;
    step(1); rd(A_LVL, v); chk("R3 level word after 1 edge", v[23:20], 32'h0);
    step(1); rd(A_LVL, v); chk("R12 level word after 2 edges", v[23:20], 32'hA);
    wr(A_DRV, 32'hCAFE_F00D);
    chk("R12 drive output", drive, 32'hCAFE_F00D);
    rd(A_DRV, v); chk("R12 drive readback", v, 32'hCAFE_F00D);
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    step(2);
    t_reset();
    t_regmap();
    t_sync_timing();
    t_rise();
    t_fall();
    t_dual();
    t_level();
    t_w1c();
    t_wins();
    t_irq();
    t_level_drive();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule